// File: doc/BRIEF.md
# Dual-Plane Busy Status Read Generator

This block sits between the array read path and the data bus of a flash macro made of two independently busy memory planes. While an embedded program or erase is running in one plane, reads that land in that plane must return progress indicators rather than stored data. Reads that land in the other plane must pass array data through untouched. The block records which operation is running, the plane it occupies, the bit 7 of the word being programmed and any erase that has been put on hold. For every read access it chooses between the array word and a status word, in which data lines 7, 6 and 2 are replaced.

The operation timers and the array itself live outside. The sequencer reports a start, a finish, a suspend and a resume as single-cycle strobes. The read path presents one strobe per new access, which comes from a falling output-enable or chip-enable edge, together with the array word for that address. The block also produces the drive-low enable for a shared open-drain ready/busy wire.

The plane is the top address bit. The sector is the address shifted right by `SECT_SHIFT`.

Top module: `dual_plane_status`

## Requirements
- R1: After reset the ready/busy drive is off, `rdData` is all zeros, no erase is on hold and both toggle bits are 0.
- R2: A start is taken only when no operation is running. An erase start is also refused while an erase is on hold. A start that is taken turns the ready/busy drive on in the following cycle. A start that is refused changes nothing.
- R3: On a read in the plane of a running program, bit 7 returns the complement of bit 7 of the word being programmed. When no erase is on hold, bit 2 returns 1.
- R4: On a read in the plane of a running erase, bit 7 returns 0 and bit 2 returns the erase toggle, which then inverts.
- R5: On each read in the busy plane, bit 6 returns the toggle bit, which then inverts. Every start and every resume clears both toggle bits, so the first poll returns 0.
- R6: A read outside the busy plane and outside any held sector returns the array word on all bits, and it leaves the toggle bits unchanged.
- R7: A suspend is taken only while an erase is running, and it turns the ready/busy drive off. A read of the held sector then returns 1 on bits 7 and 6 and the bit 2 toggle, which inverts. A read of any other sector returns array data.
- R8: For a program started while an erase is on hold, bits 7 and 6 behave as in R3 and R5, and bit 2 toggles. Busy-plane status has priority over held-sector status.
- R9: A resume, taken only when an erase is on hold and nothing is running, restarts the held erase in its own plane with both toggle bits cleared and turns the ready/busy drive on.
- R10: A finish strobe ends the running operation. It turns the ready/busy drive off in the next cycle, and later reads of that plane return array data.
- R11: `rdData` changes only in the cycle after `rdStrobe` and holds its value otherwise. Bit positions 7, 6 and 2 are fixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Sequencer starts an operation |
| startErase | input | 1 | 1 = erase, 0 = program |
| startAddr | input | ADDR_W | Target address (program) or any address in the sector (erase) |
| startData | input | DATA_W | Word being programmed |
| doneStrobe | input | 1 | Running operation has finished |
| suspendReq | input | 1 | Put the running erase on hold |
| resumeReq | input | 1 | Restart the erase on hold |
| rdStrobe | input | 1 | New read access began |
| rdAddr | input | ADDR_W | Read address |
| arrayData | input | DATA_W | Array word at `rdAddr` |
| rdData | output | DATA_W | Word returned for the last read |
| rbPullLow | output | 1 | 1 = pull the open-drain ready/busy wire low |

## Verification
The hardest state to reach is a program that runs inside an erase suspension and then reads of the held sector before and after that program finishes. In that state the busy-plane status and the held-sector status compete for the same address, and a single bit 2 toggle is shared between them. The stimulus erases a sector, suspends the erase, starts a program in the same plane and polls the program address and the held sector in turn. It then finishes the program, polls the held sector again and resumes the erase. Along the way it tries an erase start that must be refused. The expected toggle phase is counted by hand across all of these steps.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [1:0] {
    SEL_ARRAY = 2'd0,
    SEL_PROG  = 2'd1,
    SEL_ERASE = 2'd2,
    SEL_HELD  = 2'd3
  } selMode_t;

  typedef struct packed {
    logic     load;
    logic     tgClear;
    logic     flip6;
    logic     flip2;
    selMode_t mode;
    logic     progTog2;
    logic     progBit7;
  } dpsStrobe_t;

  localparam int BIT_POLL = 7;
  localparam int BIT_TOG  = 6;
  localparam int BIT_SUSP = 2;
endpackage

// File: rtl/dps_ctrl.sv
module dps_ctrl
  import dps_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int SECT_SHIFT = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic              startErase,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] startData,
  input  logic              doneStrobe,
  input  logic              suspendReq,
  input  logic              resumeReq,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output dpsStrobe_t        strobe,
  output logic              busyQ,
  output logic              opEraseQ,
  output logic              planeQ,
  output logic              heldQ,
  output logic [ADDR_W-SECT_SHIFT-1:0] heldSectQ
);
  localparam int SECT_W = ADDR_W - SECT_SHIFT;

  logic [ADDR_W-1:0] opAddr;
  logic [ADDR_W-1:0] heldAddr;
  logic              opBit7;

  logic startOk, suspOk, resOk, finOk;
  logic hitBusy, hitHeld;
  logic [SECT_W-1:0] rdSect;

  assign startOk = startValid && !busyQ && !(startErase && heldQ);
  assign finOk   = doneStrobe && busyQ;
  assign suspOk  = suspendReq && busyQ && opEraseQ;
  assign resOk   = resumeReq && heldQ && !busyQ;

  assign planeQ    = opAddr[ADDR_W-1];
  assign heldSectQ = heldAddr[ADDR_W-1:SECT_SHIFT];
  assign rdSect    = rdAddr[ADDR_W-1:SECT_SHIFT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      opEraseQ <= 1'b0;
      opAddr   <= '0;
      opBit7   <= 1'b0;
      heldQ    <= 1'b0;
      heldAddr <= '0;
    end else if (startOk) begin
      busyQ    <= 1'b1;
      opEraseQ <= startErase;
      opAddr   <= startAddr;
      opBit7   <= startData[BIT_POLL];
    end else if (finOk) begin
      busyQ <= 1'b0;
    end else if (suspOk) begin
      busyQ    <= 1'b0;
      heldQ    <= 1'b1;
      heldAddr <= opAddr;
    end else if (resOk) begin
      busyQ    <= 1'b1;
      opEraseQ <= 1'b1;
      opAddr   <= heldAddr;
      heldQ    <= 1'b0;
    end
  end

  // busy-plane status wins over held-sector status
  assign hitBusy = busyQ && (rdAddr[ADDR_W-1] == planeQ);
  assign hitHeld = heldQ && !hitBusy && (rdSect == heldSectQ);

  always_comb begin
    strobe          = '0;
    strobe.load     = rdStrobe;
    strobe.tgClear  = startOk || resOk;
    strobe.progTog2 = heldQ;
    strobe.progBit7 = ~opBit7;
    if (hitBusy) strobe.mode = opEraseQ ? SEL_ERASE : SEL_PROG;
    else if (hitHeld) strobe.mode = SEL_HELD;
    else strobe.mode = SEL_ARRAY;
    strobe.flip6 = rdStrobe && hitBusy;
    strobe.flip2 = rdStrobe && ((hitBusy && (opEraseQ || heldQ)) || hitHeld);
  end
endmodule

// File: rtl/dps_datapath.sv
module dps_datapath
  import dps_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpsStrobe_t        strobe,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData
);
  logic tog6, tog2;
  logic [DATA_W-1:0] muxOut;

  always_comb begin
    muxOut = arrayData;
    case (strobe.mode)
      SEL_PROG: begin
        muxOut[BIT_POLL] = strobe.progBit7;
        muxOut[BIT_TOG]  = tog6;
        muxOut[BIT_SUSP] = strobe.progTog2 ? tog2 : 1'b1;
      end
      SEL_ERASE: begin
        muxOut[BIT_POLL] = 1'b0;
        muxOut[BIT_TOG]  = tog6;
        muxOut[BIT_SUSP] = tog2;
      end
      SEL_HELD: begin
        muxOut[BIT_POLL] = 1'b1;
        muxOut[BIT_TOG]  = 1'b1;
        muxOut[BIT_SUSP] = tog2;
      end
      default: muxOut = arrayData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tog6   <= 1'b0;
      tog2   <= 1'b0;
      rdData <= '0;
    end else begin
      if (strobe.tgClear) begin
        tog6 <= 1'b0;
        tog2 <= 1'b0;
      end else begin
        if (strobe.flip6) tog6 <= ~tog6;
        if (strobe.flip2) tog2 <= ~tog2;
      end
      if (strobe.load) rdData <= muxOut;
    end
  end
endmodule

// File: rtl/dual_plane_status.sv
module dual_plane_status
  import dps_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int SECT_SHIFT = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic              startErase,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] startData,
  input  logic              doneStrobe,
  input  logic              suspendReq,
  input  logic              resumeReq,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData,
  output logic              rbPullLow
);
  dpsStrobe_t strobe;
  logic busyQ, opEraseQ, planeQ, heldQ;
  logic [ADDR_W-SECT_SHIFT-1:0] heldSectQ;

  dps_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_SHIFT(SECT_SHIFT)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .startValid(startValid), .startErase(startErase),
    .startAddr(startAddr), .startData(startData),
    .doneStrobe(doneStrobe), .suspendReq(suspendReq), .resumeReq(resumeReq),
    .rdStrobe(rdStrobe), .rdAddr(rdAddr),
    .strobe(strobe), .busyQ(busyQ), .opEraseQ(opEraseQ), .planeQ(planeQ),
    .heldQ(heldQ), .heldSectQ(heldSectQ)
  );

  dps_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .arrayData(arrayData), .rdData(rdData)
  );

  assign rbPullLow = busyQ;
endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int SECT_SHIFT = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              startValid,
  input logic              startErase,
  input logic              doneStrobe,
  input logic              rdStrobe,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] arrayData,
  input logic [DATA_W-1:0] rdData,
  input logic              rbPullLow,
  input logic              busyQ,
  input logic              opEraseQ,
  input logic              planeQ,
  input logic              heldQ,
  input logic [ADDR_W-SECT_SHIFT-1:0] heldSectQ
);
  logic inBusy, inHeld;
  assign inBusy = busyQ && (rdAddr[ADDR_W-1] == planeQ);
  assign inHeld = heldQ && !inBusy && (rdAddr[ADDR_W-1:SECT_SHIFT] == heldSectQ);

  p_drive_on_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    startValid && !busyQ && !(startErase && heldQ) |=> rbPullLow);

  p_erase_bit7_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && inBusy && opEraseQ |=> !rdData[7]);

  p_idle_true_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && !inBusy && !inHeld |=> rdData == $past(arrayData));

  p_held_sector_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && inHeld |=> rdData[7] && rdData[6]);

  p_release_on_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe && busyQ |=> !rbPullLow);

  p_hold_data_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> $stable(rdData));
endmodule

bind dual_plane_status dps_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_SHIFT(SECT_SHIFT)
) i_chk (
  .clk(clk), .rstN(rstN), .startValid(startValid), .startErase(startErase),
  .doneStrobe(doneStrobe), .rdStrobe(rdStrobe), .rdAddr(rdAddr),
  .arrayData(arrayData), .rdData(rdData), .rbPullLow(rbPullLow),
  .busyQ(busyQ), .opEraseQ(opEraseQ), .planeQ(planeQ), .heldQ(heldQ),
  .heldSectQ(heldSectQ)
);

// File: tb/test_dual_plane_status.sv
module test_dual_plane_status;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0, startErase = 1'b0;
  logic [19:0] startAddr = '0;
  logic [15:0] startData = '0;
  logic        doneStrobe = 1'b0, suspendReq = 1'b0, resumeReq = 1'b0;
  logic        rdStrobe = 1'b0;
  logic [19:0] rdAddr = '0;
  logic [15:0] arrayData = '0;
  logic [15:0] rdData;
  logic        rbPullLow;

  int checks = 0;
  int errors = 0;
  logic [15:0] expQ[$];
  string       tagQ[$];
  logic        sampleNext = 1'b0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  dual_plane_status i_dual_plane_status (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startErase(startErase),
    .startAddr(startAddr), .startData(startData), .doneStrobe(doneStrobe),
    .suspendReq(suspendReq), .resumeReq(resumeReq), .rdStrobe(rdStrobe),
    .rdAddr(rdAddr), .arrayData(arrayData), .rdData(rdData), .rbPullLow(rbPullLow)
  );

  function automatic logic [15:0] st(input logic [15:0] a, input logic b7, b6, b2);
    logic [15:0] r;
    r = a; r[7] = b7; r[6] = b6; r[2] = b2;
    return r;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare the registered read word one cycle after each strobe
  always @(posedge clk) sampleNext <= rdStrobe;
  always @(negedge clk) begin
    if (sampleNext) begin
      if (expQ.size() == 0) check("R11 unexpected read", 16'h0, 16'h1);
      else check(tagQ.pop_front(), rdData, expQ.pop_front());
    end
  end

  task automatic rd(input logic [19:0] a, input logic [15:0] arr, exp, input string tag);
    @(negedge clk);
    rdAddr = a; arrayData = arr; rdStrobe = 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic startOp(input logic er, input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    startValid = 1'b1; startErase = er; startAddr = a; startData = d;
    @(negedge clk);
    startValid = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) doneStrobe = 1'b1;
    else if (which == 1) suspendReq = 1'b1;
    else resumeReq = 1'b1;
    @(negedge clk);
    doneStrobe = 1'b0; suspendReq = 1'b0; resumeReq = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    check("watchdog expired", 16'h0, 16'h1);
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rdData after reset", rdData, 16'h0000);
    check("R1 ready/busy after reset", {15'h0, rbPullLow}, 16'h0);

    // program in plane 0, written bit 7 = 1
    startOp(1'b0, 20'h01234, 16'h00A5);
    check("R2 drive after program start", {15'h0, rbPullLow}, 16'h1);
    rd(20'h01234, 16'h00FF, st(16'h00FF, 1'b0, 1'b0, 1'b1), "R3 R5 program poll 1");
    rd(20'h01234, 16'h00FF, st(16'h00FF, 1'b0, 1'b1, 1'b1), "R3 R5 program poll 2");
    rd(20'h80010, 16'hBEEF, 16'hBEEF, "R6 idle plane during program");
    pulse(1); // suspend during program: refused
    check("R7 suspend refused during program", {15'h0, rbPullLow}, 16'h1);
    rd(20'h01234, 16'h00FF, st(16'h00FF, 1'b0, 1'b0, 1'b1), "R5 R6 toggle not advanced by idle read");
    pulse(0);
    check("R10 release after program done", {15'h0, rbPullLow}, 16'h0);
    rd(20'h01234, 16'h00A5, 16'h00A5, "R10 true data after program");

    // erase in plane 1
    startOp(1'b1, 20'h88000, 16'h0000);
    startOp(1'b0, 20'h00100, 16'h0000); // refused: busy
    rd(20'h00100, 16'h1111, 16'h1111, "R2 start while busy refused");
    rd(20'h88004, 16'hFFFF, 16'hFF3B, "R4 erase poll 1");
    rd(20'h88004, 16'hFFFF, 16'hFF7F, "R4 R5 erase poll 2");
    pulse(0);
    rd(20'h88004, 16'hFFFF, 16'hFFFF, "R10 true data after erase");

    // erase in plane 0, held, then program inside the hold
    startOp(1'b1, 20'h08000, 16'h0000);
    pulse(1);
    check("R7 release after suspend", {15'h0, rbPullLow}, 16'h0);
    rd(20'h08004, 16'h0000, 16'h00C0, "R7 held sector poll 1");
    rd(20'h08004, 16'h0000, 16'h00C4, "R7 held sector poll 2");
    rd(20'h10000, 16'h5A5A, 16'h5A5A, "R7 other sector while held");
    startOp(1'b0, 20'h20000, 16'h0012);
    check("R2 R8 drive for program in hold", {15'h0, rbPullLow}, 16'h1);
    rd(20'h20000, 16'hFFFF, 16'hFFBB, "R8 program in hold poll 1");
    rd(20'h20000, 16'hFFFF, 16'hFFFF, "R8 program in hold poll 2");
    rd(20'h08004, 16'h0000, 16'h0080, "R8 busy status wins over held sector");
    pulse(0);
    rd(20'h08004, 16'h0000, 16'h00C4, "R7 held sector after inner program");
    startOp(1'b1, 20'h90000, 16'h0000); // refused: erase on hold
    check("R2 erase start refused while held", {15'h0, rbPullLow}, 16'h0);
    rd(20'h90000, 16'h2222, 16'h2222, "R2 refused erase leaves plane idle");
    pulse(2);
    check("R9 drive after resume", {15'h0, rbPullLow}, 16'h1);
    rd(20'h08004, 16'hFFFF, 16'hFF3B, "R9 resumed erase poll");
    pulse(0);
    check("R10 release after resumed erase", {15'h0, rbPullLow}, 16'h0);
    rd(20'h08004, 16'hFFFF, 16'hFFFF, "R10 true data after resumed erase");

    repeat (3) @(negedge clk);
    check("R11 all reads observed", 16'(expQ.size()), 16'h0);
    finish();
  end
endmodule